// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit collects the event pulses produced by an I2C controller's protocol engine and turns them into sticky status flags, a single interrupt request and a legacy vector code. Each single-cycle event pulse on `evt_i` latches a status flag that stays set until software writes a one to it. An enable register selects which latched flags may drive the interrupt line. The bus-busy level is shown live in the status word and is never latched.

Software reaches the unit through a small register port: address 0 holds the enables, address 1 the status, and address 2 the vector. The vector reports the most urgent pending event among the five oldest ones as a number from 1 to 5, or 0 when none is pending. A read strobe on the vector address clears the flag it reports. Read data is combinational from the address, so software sees a value in the same cycle it presents the address. Side effects of a read or write take hold at the next clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: After synchronous reset the status and enable registers are zero, `irq_o` is low and the vector reads 0.
- R2: A one on `evt_i` bit k in a cycle sets status bit k at the next edge, for these positions: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero / general call, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 receive drain, 14 transmit drain; the bit then holds.
- R3: A write to address 1 clears every status bit whose write-data bit is one and leaves the others unchanged; several bits may clear in one write.
- R4: When an event pulse and a clear of the same status bit fall in one cycle, the bit is set after the edge.
- R5: `irq_o` is high exactly while some status bit and the same enable bit (address 0, same positions as R2) are both one.
- R6: An event whose enable bit is zero still sets its status bit but does not raise `irq_o`.
- R7: Status bit 12 always equals `bus_busy_i` in the same cycle; it has no enable bit and writes cannot clear it.
- R8: Address 2 reads 0 when status bits 0 to 4 are all zero, otherwise the code n+1 for the lowest set bit n among them: 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready.
- R9: A read strobe at address 2 clears the status bit its code reports at the next edge; with code 0 it changes nothing.
- R10: An event pulse on the bit a vector read reports, in the same cycle as that read, leaves the bit set.
- R11: Bits 5, 6, 7 and 15 of the status and enable registers read zero and ignore writes; writes to address 2 have no effect and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | Event pulses, one bit per status position |
| bus_busy_i | input | 1 | Live bus-busy level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effect on vector only) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the presented address |
| irq_o | output | 1 | Interrupt request |

## Verification
Two clearing paths meet a setting path in one cycle: an event pulse can coincide with a write-one-to-clear of the same bit, and with a vector read that reports that same bit. The bench drives both collisions on purpose and follows them with a plain status read. The status bit must then still read one, and the vector must report the same code again. A stream of pseudo-random pulses, writes and reads then mixes all three paths, and a behavioural model checks the read data and `irq_o` on every cycle.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    localparam int REG_W    = 16;
    localparam int ADDR_W   = 2;
    localparam int VEC_SRCS = 5;
    localparam int BUSY_BIT = 12;

    // Positions that latch events; bus busy and reserved bits excluded.
    localparam logic [REG_W-1:0] STICKY_MASK = 16'h6F1F;

    typedef enum logic [ADDR_W-1:0] {
        A_ENABLE = 2'd0,
        A_STATUS = 2'd1,
        A_VECTOR = 2'd2,
        A_SPARE  = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        V_NONE   = 3'd0,
        V_ARB    = 3'd1,
        V_NACK   = 3'd2,
        V_ACCESS = 3'd3,
        V_RXRDY  = 3'd4,
        V_TXRDY  = 3'd5
    } vec_code_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_addr_e        addr;
        logic [REG_W-1:0] data;
    } reg_req_t;

    // Lowest pending source wins.
    function automatic vec_code_e pick_vector(input logic [VEC_SRCS-1:0] pend);
        vec_code_e c;
        c = V_NONE;
        for (int i = VEC_SRCS - 1; i >= 0; i--) begin
            if (pend[i]) c = vec_code_e'(3'(i + 1));
        end
        return c;
    endfunction

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            logic q;
            always_ff @(posedge clk) begin
                if (rst)           q <= 1'b0;
                else if (set_i[i]) q <= 1'b1;
                else if (clr_i[i]) q <= 1'b0;
            end
            assign q_o[i] = q;
        end else begin : g_tied
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
    import irq_unit_pkg::*;
(
    input  logic [VEC_SRCS-1:0] pend_i,
    output vec_code_e           code_o,
    output logic [REG_W-1:0]    pick_o
);
    logic [VEC_SRCS-1:0] lower_seen;

    assign code_o = pick_vector(pend_i);

    always_comb begin
        pick_o = '0;
        lower_seen[0] = 1'b0;
        for (int i = 1; i < VEC_SRCS; i++) begin
            lower_seen[i] = lower_seen[i-1] | pend_i[i-1];
        end
        for (int i = 0; i < VEC_SRCS; i++) begin
            pick_o[i] = pend_i[i] & ~lower_seen[i];
        end
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  evt_i,
    input  logic              bus_busy_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    reg_req_t         req;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] enable_q;
    logic [REG_W-1:0] stat_clr;
    logic [REG_W-1:0] vec_pick;
    vec_code_e        vec_code;
    logic [REG_W-1:0] busy_word;

    assign req.wr   = reg_wr_i;
    assign req.rd   = reg_rd_i;
    assign req.addr = reg_addr_e'(reg_addr_i);
    assign req.data = reg_wdata_i;

    irq_vec_sel u_vec (
        .pend_i (status_q[VEC_SRCS-1:0]),
        .code_o (vec_code),
        .pick_o (vec_pick)
    );

    always_comb begin
        stat_clr = '0;
        if (req.wr && req.addr == A_STATUS) stat_clr = req.data;
        if (req.rd && req.addr == A_VECTOR) stat_clr = stat_clr | vec_pick;
    end

    irq_sticky_bank #(.W(REG_W), .MASK(STICKY_MASK)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i),
        .clr_i (stat_clr),
        .q_o   (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                                 enable_q <= '0;
        else if (req.wr && req.addr == A_ENABLE) enable_q <= req.data & STICKY_MASK;
    end

    always_comb begin
        busy_word = '0;
        busy_word[BUSY_BIT] = bus_busy_i;
    end

    always_comb begin
        unique case (req.addr)
            A_ENABLE: reg_rdata_o = enable_q;
            A_STATUS: reg_rdata_o = status_q | busy_word;
            A_VECTOR: reg_rdata_o = REG_W'(vec_code);
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(status_q & enable_q);

endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
    import irq_unit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [REG_W-1:0]  evt_i,
    input logic              bus_busy_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [REG_W-1:0]  reg_wdata_i,
    input logic [REG_W-1:0]  reg_rdata_o,
    input logic              irq_o,
    input logic [REG_W-1:0]  status_q,
    input logic [REG_W-1:0]  enable_q
);
    localparam logic [REG_W-1:0] RSV = 16'h80E0;

    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        ((evt_i & STICKY_MASK) != '0) |=>
        ((status_q & $past(evt_i & STICKY_MASK)) == $past(evt_i & STICKY_MASK)));

    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_addr_i == 2'd1) |=>
        ((status_q & $past(reg_wdata_i & ~evt_i)) == '0));

    a_r6_no_enable_no_irq: assert property (@(posedge clk) disable iff (rst)
        (enable_q == '0) |-> !irq_o);

    a_r7_busy_live: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == 2'd1) |-> (reg_rdata_o[BUSY_BIT] == bus_busy_i));

    a_r8_arb_first: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == 2'd2 && status_q[0]) |-> (reg_rdata_o == 16'd1));

    a_r9_vec_read_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && reg_addr_i == 2'd2 && reg_rdata_o == 16'd2 && !evt_i[1]) |=>
        !status_q[1]);

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o & RSV) == '0);
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt_i),
    .bus_busy_i  (bus_busy_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .status_q    (status_q),
    .enable_q    (enable_q)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt_i = '0;
    logic        bus_busy_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model state
    logic [15:0] m_stat = '0;
    logic [15:0] m_en   = '0;
    localparam logic [15:0] EVT_BITS = 16'h6F1F;

    always #10 clk = ~clk;

    irq_status_unit u0 (
        .clk(clk), .rst(rst), .evt_i(evt_i), .bus_busy_i(bus_busy_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    function automatic int model_code();
        for (int b = 0; b < 5; b++) if (m_stat[b]) return b + 1;
        return 0;
    endfunction

    function automatic logic [15:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_en;
            2'd1:    return m_stat | (bus_busy_i ? 16'h1000 : 16'h0000);
            2'd2:    return 16'(model_code());
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before posedge, advance model.
    task automatic step(input string tag, input logic [15:0] ev, input logic wr,
                        input logic rd, input logic [1:0] a,
                        input logic [15:0] wd, input logic bb);
        logic [15:0] clr;
        int          c;
        @(negedge clk);
        evt_i = ev; reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = a;
        reg_wdata_i = wd; bus_busy_i = bb;
        #2;
        check(tag, "rdata", reg_rdata_o, model_read(a));
        check(tag, "irq", {15'd0, irq_o}, {15'd0, |(m_stat & m_en)});
        clr = '0;
        if (wr && a == 2'd1) clr = wd;
        c = model_code();
        if (rd && a == 2'd2 && c != 0) clr[c-1] = 1'b1;
        m_stat = ((ev & EVT_BITS) | (m_stat & ~clr)) & EVT_BITS;
        if (wr && a == 2'd0) m_en = wd & EVT_BITS;
    endtask

    task automatic peek(input string tag, input logic [1:0] a, input logic bb);
        step(tag, 16'h0, 1'b0, 1'b0, a, 16'h0, bb);
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        peek("R1", 2'd0, 1'b0); peek("R1", 2'd1, 1'b0); peek("R1", 2'd2, 1'b0);
        // R2 / R6: every event with enables off
        step("R2", 16'hFFFF, 1'b0, 1'b0, 2'd1, 16'h0, 1'b0);
        peek("R2", 2'd1, 1'b0);
        peek("R6", 2'd1, 1'b0);
        peek("R8", 2'd2, 1'b0);
        // R3 clear two bits, then write zero
        step("R3", 16'h0, 1'b1, 1'b0, 2'd1, 16'h0003, 1'b0);
        peek("R3", 2'd1, 1'b0);
        step("R3", 16'h0, 1'b1, 1'b0, 2'd1, 16'h0000, 1'b0);
        peek("R3", 2'd1, 1'b0);
        // R4 same-cycle set and clear
        step("R4", 16'h0004, 1'b1, 1'b0, 2'd1, 16'h0004, 1'b0);
        peek("R4", 2'd1, 1'b0);
        // R5 enable one pending source
        step("R5", 16'h0, 1'b1, 1'b0, 2'd0, 16'h0010, 1'b0);
        peek("R5", 2'd0, 1'b0);
        step("R5", 16'h0, 1'b1, 1'b0, 2'd1, 16'h0010, 1'b0);
        peek("R5", 2'd1, 1'b0);
        // R7 live busy, not clearable
        peek("R7", 2'd1, 1'b1);
        step("R7", 16'h0, 1'b1, 1'b0, 2'd1, 16'h1000, 1'b1);
        peek("R7", 2'd1, 1'b1);
        peek("R7", 2'd1, 1'b0);
        // R8 / R9 vector priority and read-clear
        step("R9", 16'h0, 1'b0, 1'b1, 2'd2, 16'h0, 1'b0);
        peek("R8", 2'd2, 1'b0);
        step("R9", 16'h0, 1'b0, 1'b1, 2'd2, 16'h0, 1'b0);
        peek("R9", 2'd1, 1'b0);
        step("R9", 16'h0, 1'b0, 1'b1, 2'd2, 16'h0, 1'b0);
        peek("R9", 2'd2, 1'b0);
        // R10 pulse during the read that reports it
        step("R10", 16'h0002, 1'b0, 1'b0, 2'd1, 16'h0, 1'b0);
        step("R10", 16'h0002, 1'b0, 1'b1, 2'd2, 16'h0, 1'b0);
        peek("R10", 2'd2, 1'b0);
        peek("R10", 2'd1, 1'b0);
        // R9 read with nothing pending
        step("R9", 16'h0, 1'b1, 1'b0, 2'd1, 16'hFFFF, 1'b0);
        step("R9", 16'h0, 1'b0, 1'b1, 2'd2, 16'h0, 1'b0);
        peek("R9", 2'd1, 1'b0);
        // R11 reserved bits, vector write, spare address
        step("R11", 16'h0, 1'b1, 1'b0, 2'd0, 16'hFFFF, 1'b0);
        peek("R11", 2'd0, 1'b0);
        step("R11", 16'h0008, 1'b0, 1'b0, 2'd1, 16'h0, 1'b0);
        step("R11", 16'h0, 1'b1, 1'b0, 2'd2, 16'hFFFF, 1'b0);
        peek("R11", 2'd1, 1'b0);
        peek("R11", 2'd3, 1'b0);
        // R3 / R4 / R9 mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            logic [1:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[1:0];
            step("R4", (lfsr[7:5] == 3'd0) ? lfsr : (lfsr & 16'h0013),
                 lfsr[2] & ~lfsr[3], lfsr[3], a, {lfsr[7:0], lfsr[15:8]}, lfsr[9]);
        end
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule